// File: doc/BRIEF.md
# Four-Stage Escalating Watchdog

The block is a watchdog that runs through four timed stages in turn. Each stage has its own timeout, counted in ticks of a programmable prescaler, and its own action. When a stage's timeout runs out, the block performs that action and moves on to the next stage. After the last stage it wraps back to the first. The four possible actions are: no action, latching an interrupt, a timed CPU reset pulse, and a timed system reset pulse. The two reset pulses each have their own selectable width.

Software drives the block through a simple one-cycle write port. A key register locks and unlocks every other register. Most configuration fields are staged in shadow copies, and they take effect only when software writes a commit address. A feed write restarts the sequence from the first stage. A boot bit keeps the watchdog running even while the ordinary enable bit is clear.

Top module: `stage_watchdog`

## Requirements
- R1: There are four stages, numbered 0 to 3. Each stage expires after its own timeout of T ticks, and a value of 0 counts as 1. On expiry the block moves to the next stage, and after stage 3 it goes back to stage 0. Stage i's timeout is written at address 2+i.
- R2: Each stage has a 2-bit action held in CTRL bits [2i+3:2i+2]. The codes are: 0 no action, 1 set the interrupt status, 2 start a CPU reset pulse, 3 start a system reset pulse. A stage with code 0 still times out and advances.
- R3: Any write to address 7 (feed) clears the prescaler and tick counters and returns the block to stage 0, so the full stage-0 timeout starts again.
- R4: The prescaler value P is held in address 1, bits [15:0]. The block makes one tick every P clocks, and P = 0 counts as 1. Once running, stage 0 expires on the P·T-th clock edge.
- R5: The CPU pulse width code is in CTRL[12:10] and the system pulse width code is in CTRL[15:13]. Codes 0 to 7 select 100, 200, 300, 400, 500, 800, 1600 and 3200 ns. Each width becomes ceil(ns / CLK_NS) clock cycles of active-high output.
- R6: Writing the value KEY to address 8 unlocks the block. Writing any other value there locks it. While locked, writes to every other address are ignored. The block comes out of reset unlocked.
- R7: The boot bit (CTRL[1]), the stage actions, the pulse width codes, the prescaler and the timeouts are written to shadow copies. They take effect only on a write to address 6. The enable bit CTRL[0] takes effect at once.
- R8: When the active boot bit is set, the watchdog counts and expires even while the enable bit is 0.
- R9: The interrupt status is cleared by writing 1 to address 9 bit 1. Address 9 bit 0 is the interrupt enable, and irq_o is the status ANDed with that enable. A set and a clear in the same cycle leave the status set.
- R10: While both the enable bit and the active boot bit are 0, the counters are cleared and the stage is held at 0. A later start runs from the beginning of stage 0.
- R11: After reset, all outputs are low and the watchdog is stopped. All actions are 0, the prescaler is 1, and every timeout is DEF_TIMEOUT.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Write strobe, one cycle per write |
| wr_addr_i | input | 4 | Register address |
| wr_data_i | input | 32 | Write data |
| irq_o | output | 1 | Interrupt request (status AND enable) |
| cpu_rst_o | output | 1 | CPU reset pulse |
| sys_rst_o | output | 1 | System reset pulse |

## Verification
The hardest situation to reach from the ports is a full lap around the stages. The bench has to bring the block back into stage 0 after stages 1 to 3 have silently expired, while their actions stay invisible. The bench sets a distinct timeout for each stage and gives only stage 0 an interrupt action. It clears the interrupt after the first expiry and times the second interrupt, which can only appear at the right edge if every intermediate stage counted its full timeout. The same idea of timing an interrupt that comes later is used to show that a feed made in stage 1, or a stop and restart made in stage 1, throws away the partial progress.

// File: rtl/swd_pkg.sv
package swd_pkg;

  localparam int NSTAGE = 4;
  localparam int DW     = 32;
  localparam int AW     = 4;
  localparam int PREW   = 16;
  localparam int LENW   = 3;

  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_IRQ  = 2'd1,
    ACT_CPU  = 2'd2,
    ACT_SYS  = 2'd3
  } act_e;

  localparam logic [AW-1:0] A_CTRL     = 4'd0;
  localparam logic [AW-1:0] A_PRESCALE = 4'd1;
  localparam logic [AW-1:0] A_TO0      = 4'd2;
  localparam logic [AW-1:0] A_COMMIT   = 4'd6;
  localparam logic [AW-1:0] A_FEED     = 4'd7;
  localparam logic [AW-1:0] A_KEY      = 4'd8;
  localparam logic [AW-1:0] A_IRQ      = 4'd9;

  // pulse width code to nanoseconds
  function automatic int unsigned code_ns(logic [LENW-1:0] c);
    case (c)
      3'd0:    return 100;
      3'd1:    return 200;
      3'd2:    return 300;
      3'd3:    return 400;
      3'd4:    return 500;
      3'd5:    return 800;
      3'd6:    return 1600;
      default: return 3200;
    endcase
  endfunction

  function automatic int unsigned ns_to_cycles(int unsigned ns, int unsigned clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

endpackage

// File: rtl/swd_regs.sv
module swd_regs
  import swd_pkg::*;
#(
  parameter int          TW           = 32,
  parameter logic [31:0] KEY          = 32'hC0DE_5AFE,
  parameter int          DEF_TIMEOUT  = 1000,
  parameter logic        BOOT_DEFAULT = 1'b0
) (
  input  logic            clk_i,
  input  logic            rst_i,
  input  logic            wr_en_i,
  input  logic [AW-1:0]   wr_addr_i,
  input  logic [DW-1:0]   wr_data_i,
  output logic            enable_o,
  output logic            boot_o,
  output act_e            act_o     [NSTAGE],
  output logic [TW-1:0]   timeout_o [NSTAGE],
  output logic [PREW-1:0] prescale_o,
  output logic [LENW-1:0] cpu_len_o,
  output logic [LENW-1:0] sys_len_o,
  output logic            irq_en_o,
  output logic            feed_o,
  output logic            irq_clr_o
);

  logic            unlocked_q, enable_q, ien_q;
  logic            sh_boot_q, ac_boot_q;
  logic [PREW-1:0] sh_pre_q, ac_pre_q;
  logic [LENW-1:0] sh_cpu_q, ac_cpu_q, sh_sys_q, ac_sys_q;
  act_e            sh_act_q [NSTAGE];
  act_e            ac_act_q [NSTAGE];
  logic [TW-1:0]   sh_to_q  [NSTAGE];
  logic [TW-1:0]   ac_to_q  [NSTAGE];

  logic wr_ok, commit;
  assign wr_ok  = wr_en_i && unlocked_q && (wr_addr_i != A_KEY);
  assign commit = wr_ok && (wr_addr_i == A_COMMIT);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      unlocked_q <= 1'b1;
      enable_q   <= 1'b0;
      ien_q      <= 1'b0;
      sh_boot_q  <= BOOT_DEFAULT;
      ac_boot_q  <= BOOT_DEFAULT;
      sh_pre_q   <= PREW'(1);
      ac_pre_q   <= PREW'(1);
      sh_cpu_q   <= '0;
      ac_cpu_q   <= '0;
      sh_sys_q   <= '0;
      ac_sys_q   <= '0;
      for (int i = 0; i < NSTAGE; i++) begin
        sh_act_q[i] <= ACT_NONE;
        ac_act_q[i] <= ACT_NONE;
        sh_to_q[i]  <= TW'(DEF_TIMEOUT);
        ac_to_q[i]  <= TW'(DEF_TIMEOUT);
      end
    end else begin
      if (wr_en_i && wr_addr_i == A_KEY)
        unlocked_q <= (wr_data_i == KEY);
      if (wr_ok) begin
        case (wr_addr_i)
          A_CTRL: begin
            enable_q  <= wr_data_i[0];
            sh_boot_q <= wr_data_i[1];
            for (int i = 0; i < NSTAGE; i++)
              sh_act_q[i] <= act_e'(wr_data_i[2+2*i +: 2]);
            sh_cpu_q <= wr_data_i[10 +: LENW];
            sh_sys_q <= wr_data_i[13 +: LENW];
          end
          A_PRESCALE: sh_pre_q <= wr_data_i[PREW-1:0];
          A_IRQ:      ien_q    <= wr_data_i[0];
          default: ;
        endcase
        for (int i = 0; i < NSTAGE; i++)
          if (wr_addr_i == A_TO0 + AW'(i))
            sh_to_q[i] <= wr_data_i[TW-1:0];
      end
      if (commit) begin
        ac_boot_q <= sh_boot_q;
        ac_pre_q  <= sh_pre_q;
        ac_cpu_q  <= sh_cpu_q;
        ac_sys_q  <= sh_sys_q;
        for (int i = 0; i < NSTAGE; i++) begin
          ac_act_q[i] <= sh_act_q[i];
          ac_to_q[i]  <= sh_to_q[i];
        end
      end
    end
  end

  assign enable_o   = enable_q;
  assign boot_o     = ac_boot_q;
  assign prescale_o = ac_pre_q;
  assign cpu_len_o  = ac_cpu_q;
  assign sys_len_o  = ac_sys_q;
  assign irq_en_o   = ien_q;
  assign feed_o     = wr_ok && (wr_addr_i == A_FEED);
  assign irq_clr_o  = wr_ok && (wr_addr_i == A_IRQ) && wr_data_i[1];

  for (genvar g = 0; g < NSTAGE; g++) begin : g_out
    assign act_o[g]     = ac_act_q[g];
    assign timeout_o[g] = ac_to_q[g];
  end

  // R6: a locked block ignores every write except the key
  assert_locked_ignore_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    (wr_en_i && !unlocked_q && wr_addr_i != A_KEY)
      |=> ($stable(enable_q) && $stable(sh_pre_q) && $stable(ien_q) && $stable(ac_pre_q)));

  // R7: active configuration only moves on a commit write
  assert_commit_only_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    !commit |=> ($stable(ac_pre_q) && $stable(ac_boot_q) && $stable(ac_cpu_q) && $stable(ac_sys_q)));

endmodule

// File: rtl/swd_core.sv
module swd_core
  import swd_pkg::*;
#(
  parameter int TW = 32
) (
  input  logic            clk_i,
  input  logic            rst_i,
  input  logic            run_i,
  input  logic            feed_i,
  input  logic [PREW-1:0] prescale_i,
  input  logic [TW-1:0]   timeout_i [NSTAGE],
  input  act_e            act_i     [NSTAGE],
  output logic            expire_o,
  output act_e            fire_act_o
);

  localparam int SW = $clog2(NSTAGE);

  logic [PREW-1:0] pcnt_q;
  logic [TW-1:0]   tcnt_q;
  logic [SW-1:0]   stage_q;

  logic [PREW-1:0] pre_eff;
  logic [TW-1:0]   to_eff;
  logic            tick, last;

  assign pre_eff    = (prescale_i == '0) ? PREW'(1) : prescale_i;
  assign to_eff     = (timeout_i[stage_q] == '0) ? TW'(1) : timeout_i[stage_q];
  assign tick       = run_i && (pcnt_q >= pre_eff - PREW'(1));
  assign last       = (tcnt_q >= to_eff - TW'(1));
  assign expire_o   = tick && last && !feed_i;
  assign fire_act_o = act_i[stage_q];

  always_ff @(posedge clk_i) begin
    if (rst_i || !run_i || feed_i) begin
      pcnt_q  <= '0;
      tcnt_q  <= '0;
      stage_q <= '0;
    end else begin
      pcnt_q <= tick ? '0 : pcnt_q + PREW'(1);
      if (tick) begin
        if (last) begin
          tcnt_q  <= '0;
          stage_q <= (stage_q == SW'(NSTAGE-1)) ? '0 : stage_q + SW'(1);
        end else begin
          tcnt_q <= tcnt_q + TW'(1);
        end
      end
    end
  end

  // R3: a feed restarts the sequence
  assert_feed_restart_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    feed_i |=> (stage_q == '0 && tcnt_q == '0 && pcnt_q == '0));

  // R10: stopped watchdog is held at stage 0
  assert_idle_hold_R10: assert property (@(posedge clk_i) disable iff (rst_i)
    !run_i |=> (stage_q == '0 && tcnt_q == '0));

  // R1: the stage only moves on an expiry
  assert_stage_steady_R1: assert property (@(posedge clk_i) disable iff (rst_i)
    (run_i && !feed_i && !expire_o) |=> $stable(stage_q));

endmodule

// File: rtl/swd_pulse.sv
module swd_pulse
  import swd_pkg::*;
#(
  parameter int CLK_NS = 5
) (
  input  logic            clk_i,
  input  logic            rst_i,
  input  logic            trig_i,
  input  logic [LENW-1:0] len_code_i,
  output logic            pulse_o
);

  localparam int MAXC = (3200 + CLK_NS - 1) / CLK_NS;
  localparam int CW   = $clog2(MAXC + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] load;

  assign load = CW'(ns_to_cycles(code_ns(len_code_i), CLK_NS));

  always_ff @(posedge clk_i) begin
    if (rst_i)               cnt_q <= '0;
    else if (trig_i)         cnt_q <= load;
    else if (cnt_q != '0)    cnt_q <= cnt_q - CW'(1);
  end

  assign pulse_o = (cnt_q != '0);

  // R5: trigger starts the pulse on the next cycle
  assert_pulse_start_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    trig_i |=> pulse_o);

  // R5: pulse ends only once its count is used up
  assert_pulse_end_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(pulse_o) |-> ($past(cnt_q) == CW'(1)));

endmodule

// File: rtl/stage_watchdog.sv
module stage_watchdog
  import swd_pkg::*;
#(
  parameter int          TW           = 32,
  parameter logic [31:0] KEY          = 32'hC0DE_5AFE,
  parameter int          CLK_NS       = 5,
  parameter int          DEF_TIMEOUT  = 1000,
  parameter logic        BOOT_DEFAULT = 1'b0
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          wr_en_i,
  input  logic [3:0]    wr_addr_i,
  input  logic [31:0]   wr_data_i,
  output logic          irq_o,
  output logic          cpu_rst_o,
  output logic          sys_rst_o
);

  localparam int NPULSE = 2;

  logic            enable, boot, irq_en, feed, irq_clr, expire;
  act_e            acts [NSTAGE];
  act_e            fire_act;
  logic [TW-1:0]   tos  [NSTAGE];
  logic [PREW-1:0] prescale;
  logic [LENW-1:0] cpu_len, sys_len;
  logic [NPULSE-1:0] pulse;
  logic            irq_st_q, irq_set;

  swd_regs #(
    .TW(TW), .KEY(KEY), .DEF_TIMEOUT(DEF_TIMEOUT), .BOOT_DEFAULT(BOOT_DEFAULT)
  ) regs_i (
    .clk_i(clk_i), .rst_i(rst_i),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .enable_o(enable), .boot_o(boot), .act_o(acts), .timeout_o(tos),
    .prescale_o(prescale), .cpu_len_o(cpu_len), .sys_len_o(sys_len),
    .irq_en_o(irq_en), .feed_o(feed), .irq_clr_o(irq_clr)
  );

  swd_core #(.TW(TW)) core_i (
    .clk_i(clk_i), .rst_i(rst_i),
    .run_i(enable || boot), .feed_i(feed),
    .prescale_i(prescale), .timeout_i(tos), .act_i(acts),
    .expire_o(expire), .fire_act_o(fire_act)
  );

  for (genvar g = 0; g < NPULSE; g++) begin : g_pulse
    localparam act_e MYACT = (g == 0) ? ACT_CPU : ACT_SYS;
    swd_pulse #(.CLK_NS(CLK_NS)) pulse_i (
      .clk_i(clk_i), .rst_i(rst_i),
      .trig_i(expire && fire_act == MYACT),
      .len_code_i((g == 0) ? cpu_len : sys_len),
      .pulse_o(pulse[g])
    );
  end

  assign cpu_rst_o = pulse[0];
  assign sys_rst_o = pulse[1];

  assign irq_set = expire && (fire_act == ACT_IRQ);

  always_ff @(posedge clk_i) begin
    if (rst_i)        irq_st_q <= 1'b0;
    else if (irq_set) irq_st_q <= 1'b1;
    else if (irq_clr) irq_st_q <= 1'b0;
  end

  assign irq_o = irq_st_q && irq_en;

  // R9: a clear with no concurrent set drops the request
  assert_irq_clear_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    (irq_clr && !irq_set) |=> !irq_o);

  // R2: an interrupt-action expiry latches the status
  assert_irq_set_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    irq_set |=> irq_st_q);

endmodule

// File: tb/stage_watchdog_tb_top.sv
module stage_watchdog_tb_top;

  localparam int CLK_NS = 5;
  localparam logic [31:0] KEY = 32'hC0DE_5AFE;
  localparam logic [3:0] RA_CTRL = 4'd0, RA_PRE = 4'd1, RA_TO0 = 4'd2,
                         RA_COMMIT = 4'd6, RA_FEED = 4'd7, RA_KEY = 4'd8, RA_IRQ = 4'd9;
  localparam int BIG = 1000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic irq, cpu_rst, sys_rst;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  stage_watchdog #(.KEY(KEY), .CLK_NS(CLK_NS)) dut_i (
    .clk_i(clk), .rst_i(rst), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .irq_o(irq), .cpu_rst_o(cpu_rst), .sys_rst_o(sys_rst)
  );

  function automatic logic [31:0] ctrl_word(bit en, bit boot, int a0, int a1, int a2, int a3,
                                            int cl, int sl);
    return 32'(en) | (32'(boot) << 1) | (32'(a0) << 2) | (32'(a1) << 4) | (32'(a2) << 6)
         | (32'(a3) << 8) | (32'(cl) << 10) | (32'(sl) << 13);
  endfunction

  function automatic logic sig(int sel);
    case (sel)
      0: return irq;
      1: return cpu_rst;
      default: return sys_rst;
    endcase
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
  endtask

  task automatic setup(logic [31:0] ctrl, int pre, int t0, int t1, int t2, int t3, bit ien);
    wr(RA_CTRL, ctrl);
    wr(RA_PRE, 32'(pre));
    wr(RA_TO0, 32'(t0));
    wr(RA_TO0 + 4'd1, 32'(t1));
    wr(RA_TO0 + 4'd2, 32'(t2));
    wr(RA_TO0 + 4'd3, 32'(t3));
    wr(RA_IRQ, {31'd0, ien});
    wr(RA_COMMIT, 32'd0);
  endtask

  task automatic wait_for(int sel, int maxn, output int n);
    n = 0;
    while (!sig(sel) && n < maxn) begin
      @(posedge clk); #1;
      n++;
    end
  endtask

  task automatic width_of(int sel, output int w);
    w = 0;
    while (sig(sel) && w < 5000) begin
      @(posedge clk); #1;
      w++;
    end
  endtask

  task automatic t_reset();
    do_reset();
    chk("R11 irq low", int'(irq), 0);
    chk("R11 cpu low", int'(cpu_rst), 0);
    chk("R11 sys low", int'(sys_rst), 0);
    repeat (50) @(posedge clk);
    #1 chk("R11 stopped", int'(irq | cpu_rst | sys_rst), 0);
  endtask

  task automatic t_basic();
    int n;
    logic [31:0] c = ctrl_word(0, 0, 1, 0, 0, 0, 0, 0);
    do_reset();
    setup(c, 1, 5, BIG, BIG, BIG, 1);
    wr(RA_CTRL, c | 1);
    wait_for(0, 200, n);
    chk("R1 stage0 irq expiry", n, 5);
    setup(c, 1, 0, BIG, BIG, BIG, 1);
    wr(RA_IRQ, 32'd3);
    wr(RA_CTRL, c | 1);
    wait_for(0, 200, n);
    chk("R1 zero timeout as one", n, 1);
  endtask

  task automatic t_prescale();
    int n;
    logic [31:0] c = ctrl_word(0, 0, 1, 0, 0, 0, 0, 0);
    do_reset();
    setup(c, 3, 4, BIG, BIG, BIG, 1);
    wr(RA_CTRL, c | 1);
    wait_for(0, 200, n);
    chk("R4 prescale 3 x 4", n, 12);
    do_reset();
    setup(c, 0, 6, BIG, BIG, BIG, 1);
    wr(RA_CTRL, c | 1);
    wait_for(0, 200, n);
    chk("R4 prescale zero as one", n, 6);
  endtask

  task automatic t_chain();
    int n;
    logic [31:0] c = ctrl_word(0, 0, 0, 1, 0, 0, 0, 0);
    do_reset();
    setup(c, 1, 2, 3, BIG, BIG, 1);
    wr(RA_CTRL, c | 1);
    wait_for(0, 200, n);
    chk("R2 none stage still advances", n, 5);
  endtask

  task automatic t_wrap();
    int n;
    logic [31:0] c = ctrl_word(0, 0, 1, 0, 0, 0, 0, 0);
    do_reset();
    setup(c, 1, 2, 3, 4, 5, 1);
    wr(RA_CTRL, c | 1);
    wait_for(0, 200, n);
    chk("R1 first lap", n, 2);
    wr(RA_IRQ, 32'd3);
    chk("R9 clear drops irq", int'(irq), 0);
    wait_for(0, 200, n);
    chk("R1 wrap after stage3", n, 13);
  endtask

  task automatic t_pulses();
    int n, w;
    logic [31:0] c;
    do_reset();
    c = ctrl_word(0, 0, 2, 0, 0, 0, 0, 7);
    setup(c, 1, 3, BIG, BIG, BIG, 1);
    wr(RA_CTRL, c | 1);
    wait_for(1, 200, n);
    chk("R2 cpu action timing", n, 3);
    chk("R2 cpu action no sys", int'(sys_rst), 0);
    chk("R2 cpu action no irq", int'(irq), 0);
    width_of(1, w);
    chk("R5 cpu width code0", w, 20);
    do_reset();
    c = ctrl_word(0, 0, 2, 0, 0, 0, 5, 0);
    setup(c, 1, 3, BIG, BIG, BIG, 1);
    wr(RA_CTRL, c | 1);
    wait_for(1, 200, n);
    width_of(1, w);
    chk("R5 cpu width code5", w, 160);
    do_reset();
    c = ctrl_word(0, 0, 3, 0, 0, 0, 0, 7);
    setup(c, 1, 4, BIG, BIG, BIG, 1);
    wr(RA_CTRL, c | 1);
    wait_for(2, 200, n);
    chk("R2 sys action timing", n, 4);
    chk("R2 sys action no cpu", int'(cpu_rst), 0);
    width_of(2, w);
    chk("R5 sys width code7", w, 640);
  endtask

  task automatic t_feed();
    int n;
    logic [31:0] c = ctrl_word(0, 0, 1, 0, 0, 0, 0, 0);
    do_reset();
    setup(c, 1, 10, BIG, BIG, BIG, 1);
    wr(RA_CTRL, c | 1);
    repeat (6) @(posedge clk);
    wr(RA_FEED, 32'd0);
    chk("R3 no irq before feed expiry", int'(irq), 0);
    wait_for(0, 200, n);
    chk("R3 feed restarts stage0", n, 10);
    do_reset();
    c = ctrl_word(0, 0, 0, 1, 0, 0, 0, 0);
    setup(c, 1, 2, 20, BIG, BIG, 1);
    wr(RA_CTRL, c | 1);
    repeat (4) @(posedge clk);
    wr(RA_FEED, 32'd0);
    wait_for(0, 200, n);
    chk("R3 feed from stage1", n, 22);
  endtask

  task automatic t_lock();
    int n;
    logic [31:0] c = ctrl_word(0, 0, 1, 0, 0, 0, 0, 0);
    do_reset();
    setup(c, 1, 8, BIG, BIG, BIG, 1);
    wr(RA_CTRL, c | 1);
    wr(RA_KEY, KEY ^ 32'h1);
    wr(RA_CTRL, c);
    wait_for(0, 200, n);
    chk("R6 locked disable ignored", n, 6);
    wr(RA_IRQ, 32'd3);
    chk("R6 locked clear ignored", int'(irq), 1);
    wr(RA_KEY, KEY);
    wr(RA_IRQ, 32'd3);
    chk("R6 unlocked clear works", int'(irq), 0);
  endtask

  task automatic t_shadow();
    int n;
    logic [31:0] c = ctrl_word(0, 0, 1, 0, 0, 0, 0, 0);
    do_reset();
    setup(c, 1, 5, BIG, BIG, BIG, 1);
    wr(RA_TO0, 32'd20);
    wr(RA_CTRL, c | 1);
    wait_for(0, 200, n);
    chk("R7 uncommitted timeout unused", n, 5);
    wr(RA_CTRL, c);
    wr(RA_COMMIT, 32'd0);
    wr(RA_IRQ, 32'd3);
    wr(RA_CTRL, c | 1);
    wait_for(0, 200, n);
    chk("R7 committed timeout used", n, 20);
  endtask

  task automatic t_boot();
    int n;
    logic [31:0] c = ctrl_word(0, 1, 1, 0, 0, 0, 0, 0);
    do_reset();
    wr(RA_CTRL, c);
    wr(RA_PRE, 32'd1);
    wr(RA_TO0, 32'd4);
    wr(RA_IRQ, 32'd1);
    repeat (20) @(posedge clk);
    #1 chk("R7 boot bit waits for commit", int'(irq), 0);
    wr(RA_COMMIT, 32'd0);
    wait_for(0, 200, n);
    chk("R8 boot runs with enable 0", n, 4);
  endtask

  task automatic t_irq_gate();
    logic [31:0] c = ctrl_word(0, 0, 1, 0, 0, 0, 0, 0);
    do_reset();
    setup(c, 1, 3, BIG, BIG, BIG, 0);
    wr(RA_CTRL, c | 1);
    repeat (10) @(posedge clk);
    #1 chk("R9 masked irq low", int'(irq), 0);
    wr(RA_IRQ, 32'd1);
    chk("R9 status kept under mask", int'(irq), 1);
    wr(RA_IRQ, 32'd3);
    chk("R9 clear with enable", int'(irq), 0);
  endtask

  task automatic t_idle();
    int n;
    logic [31:0] c = ctrl_word(0, 0, 0, 1, 0, 0, 0, 0);
    do_reset();
    setup(c, 1, 3, 6, BIG, BIG, 1);
    wr(RA_CTRL, c | 1);
    repeat (3) @(posedge clk);
    wr(RA_CTRL, c);
    wr(RA_CTRL, c | 1);
    wait_for(0, 200, n);
    chk("R10 stop returns to stage0", n, 9);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_prescale();
    t_chain();
    t_wrap();
    t_pulses();
    t_feed();
    t_lock();
    t_shadow();
    t_boot();
    t_irq_gate();
    t_idle();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule